// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Level-One Data Lookup

This block answers a load request in one cycle by reading a direct-mapped data array and a two-way set-associative address translator side by side. The data array is addressed with bits that sit below the 16 KB page boundary, so it needs no translation. The translator turns the virtual page number into a physical frame number. The frame number that leaves the translator is then compared against the physical tag stored with the selected line.

The requester issues a 64-bit virtual address. One cycle later it receives a response: whether the translation was found, whether the data line hit, the 40-bit physical address, and the selected 64-bit word. A walker outside the block installs translations through one fill port, and the next memory level installs whole 64-byte lines through another. Misses are only reported. Both arrays are cleared by reset. A translation miss is reported on its own flag and always forces a data miss.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, and again after any later reset pulse, every translator entry and every data line is invalid. While reset is high and in the first cycle after it, all response outputs are zero.
- R2: `rsp_valid` is high in exactly the cycle that follows a cycle with `req_valid` high. When `rsp_valid` is low, both hit flags are low.
- R3: The translator set is vaddr[20:14] and the entry tag is vaddr[63:21]. On a translator hit, `rsp_paddr` equals {frame, vaddr[13:0]}. A request whose page number is held only in a different set misses.
- R4: On a translator miss, `rsp_cache_hit`, `rsp_paddr` and `rsp_rdata` are all zero, whatever the data array holds.
- R5: A data hit requires three things: a translator hit, a valid line at index vaddr[13:6], and a stored tag equal to the translated frame. On a data hit, `rsp_rdata` is word vaddr[5:3] of that line, where word k occupies line bits 64k+63 down to 64k.
- R6: A valid line whose stored tag differs from the translated frame is a data miss, and `rsp_rdata` is zero. Two virtual pages that map to the same frame both hit the same line.
- R7: A translator fill picks its way in this order: the way that already holds the same page number, then the first invalid way (way 0 before way 1), then the least recently used way. The two ways of a set never hold the same page number.
- R8: A translator hit marks the other way of its set as the next victim. A fill marks the way it did not write as the next victim. When a hit and a fill touch the same set in the same cycle, the mark from the fill wins.
- R9: A lookup in the same cycle as a fill to the same translator set or data line sees the contents from before the fill. The fill becomes visible to the next request.
- R10: A line fill writes the line valid bit, the physical tag and all 512 data bits at the given index, replacing any earlier line there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Load lookup request |
| req_vaddr | input | 64 | Virtual address of the load |
| tfill_valid | input | 1 | Install a translation |
| tfill_vpn | input | 50 | Virtual page number to install |
| tfill_pfn | input | 26 | Physical frame number to install |
| cfill_valid | input | 1 | Install a data line |
| cfill_index | input | 8 | Line index to write |
| cfill_ptag | input | 26 | Physical tag of the line |
| cfill_line | input | 512 | Line data, word k at bits 64k+63:64k |
| rsp_valid | output | 1 | Response present |
| rsp_tlb_hit | output | 1 | Translation found |
| rsp_cache_hit | output | 1 | Data line hit |
| rsp_paddr | output | 40 | Physical address, zero on translation miss |
| rsp_rdata | output | 64 | Selected word, zero on data miss |

## Verification
Two pairs of functions can fall in the same cycle. A lookup can meet a fill of the same translator set, and a lookup can meet a fill of the same data line. The bench drives both inputs of each pair in one cycle and expects the old contents in that response and the new contents in the next one. It also places a translator hit and a translator fill to the same set in one cycle. It then judges which victim mark survived by issuing a further fill and observing at the ports which of the older translations is still present.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    // Source of the way chosen for a translator fill
    typedef enum logic [1:0] {
        VICT_MATCH = 2'd0,   // same page number already present
        VICT_FREE  = 2'd1,   // an invalid way exists
        VICT_LRU   = 2'd2    // both valid, take the least recently used
    } vict_src_e;

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb
    import vipt_pkg::*;
#(
    parameter int VPN_W = 50,
    parameter int PFN_W = 26,
    parameter int SET_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_en,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic [1:0]       lk_way_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn
);
    localparam int SETS  = 1 << SET_W;
    localparam int TAG_W = VPN_W - SET_W;

    logic [TAG_W-1:0] tag_q [SETS][2];
    logic [PFN_W-1:0] pfn_q [SETS][2];
    logic [1:0]       vld_q [SETS];
    logic [SETS-1:0]  lru_q;       // way to replace next in each set

    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic [SET_W-1:0] f_set;
    logic [TAG_W-1:0] f_tag;
    logic [1:0]       f_match;
    vict_src_e        f_src;
    logic             f_way;

    assign lk_set = lk_vpn[SET_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:SET_W];
    assign f_set  = fill_vpn[SET_W-1:0];
    assign f_tag  = fill_vpn[VPN_W-1:SET_W];

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign lk_way_hit[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        assign f_match[w]    = vld_q[f_set][w] && (tag_q[f_set][w] == f_tag);
    end

    assign lk_pfn = lk_way_hit[1] ? pfn_q[lk_set][1] : pfn_q[lk_set][0];

    // Victim source selection
    always_comb begin
        if (|f_match) begin
            f_src = VICT_MATCH;
        end else if (vld_q[f_set] != 2'b11) begin
            f_src = VICT_FREE;
        end else begin
            f_src = VICT_LRU;
        end
    end

    always_comb begin
        unique case (f_src)
            VICT_MATCH: f_way = f_match[1];
            VICT_FREE:  f_way = vld_q[f_set][0];
            VICT_LRU:   f_way = lru_q[f_set];
            default:    f_way = 1'b0;
        endcase
    end

    // Entry contents, no reset needed: guarded by valid bits
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[f_set][f_way] <= f_tag;
            pfn_q[f_set][f_way] <= fill_pfn;
        end
    end

    // Valid and replacement state; fill update placed last so it wins
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= 2'b00;
            end
            lru_q <= '0;
        end else begin
            if (lk_en && (|lk_way_hit)) begin
                lru_q[lk_set] <= lk_way_hit[0];
            end
            if (fill_en) begin
                vld_q[f_set][f_way] <= 1'b1;
                lru_q[f_set]        <= ~f_way;
            end
        end
    end

endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
    parameter int IDX_W     = 8,
    parameter int TAG_W     = 26,
    parameter int LINE_BITS = 512,
    parameter int WORD_W    = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [$clog2(LINE_BITS/WORD_W)-1:0] rd_sel,
    output logic                 rd_valid,
    output logic [TAG_W-1:0]     rd_tag,
    output logic [WORD_W-1:0]    rd_word,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [LINE_BITS-1:0] wr_line
);
    localparam int LINES = 1 << IDX_W;
    localparam int WORDS = LINE_BITS / WORD_W;

    logic [LINE_BITS-1:0] data_q [LINES];
    logic [TAG_W-1:0]     tag_q  [LINES];
    logic [LINES-1:0]     vld_q;

    logic [LINE_BITS-1:0] rd_line;
    logic [WORD_W-1:0]    words [WORDS];

    assign rd_line  = data_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        assign words[k] = rd_line[k*WORD_W +: WORD_W];
    end

    assign rd_word = words[rd_sel];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_line;
            tag_q[wr_idx]  <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/vipt_hit_logic.sv
module vipt_hit_logic #(
    parameter int PFN_W = 26
) (
    input  logic [1:0]       way_hit,
    input  logic [PFN_W-1:0] xlat_pfn,
    input  logic             line_valid,
    input  logic [PFN_W-1:0] line_tag,
    output logic             tlb_hit,
    output logic             cache_hit
);
    assign tlb_hit   = |way_hit;
    assign cache_hit = tlb_hit && line_valid && (line_tag == xlat_pfn);
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
    parameter int VA_W      = 64,
    parameter int PA_W      = 40,
    parameter int PAGE_W    = 14,
    parameter int LINE_W    = 6,
    parameter int TLB_SET_W = 7,
    parameter int WORD_W    = 64,
    localparam int VPN_W     = VA_W - PAGE_W,
    localparam int PFN_W     = PA_W - PAGE_W,
    localparam int IDX_W     = PAGE_W - LINE_W,
    localparam int LINE_BITS = 8 << LINE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic                 tfill_valid,
    input  logic [VPN_W-1:0]     tfill_vpn,
    input  logic [PFN_W-1:0]     tfill_pfn,
    input  logic                 cfill_valid,
    input  logic [IDX_W-1:0]     cfill_index,
    input  logic [PFN_W-1:0]     cfill_ptag,
    input  logic [LINE_BITS-1:0] cfill_line,
    output logic                 rsp_valid,
    output logic                 rsp_tlb_hit,
    output logic                 rsp_cache_hit,
    output logic [PA_W-1:0]      rsp_paddr,
    output logic [WORD_W-1:0]    rsp_rdata
);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int SEL_W  = $clog2(LINE_BITS / WORD_W);

    logic [1:0]       tlb_way_hit;
    logic [PFN_W-1:0] xlat_pfn;
    logic             line_valid;
    logic [PFN_W-1:0] line_tag;
    logic [WORD_W-1:0] line_word;
    logic             tlb_hit;
    logic             cache_hit;

    vipt_tlb #(
        .VPN_W (VPN_W),
        .PFN_W (PFN_W),
        .SET_W (TLB_SET_W)
    ) u_tlb (
        .clk        (clk),
        .rst        (rst),
        .lk_en      (req_valid),
        .lk_vpn     (req_vaddr[VA_W-1:PAGE_W]),
        .lk_way_hit (tlb_way_hit),
        .lk_pfn     (xlat_pfn),
        .fill_en    (tfill_valid),
        .fill_vpn   (tfill_vpn),
        .fill_pfn   (tfill_pfn)
    );

    // Index taken below the page boundary: read overlaps translation
    vipt_line_store #(
        .IDX_W     (IDX_W),
        .TAG_W     (PFN_W),
        .LINE_BITS (LINE_BITS),
        .WORD_W    (WORD_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (req_vaddr[PAGE_W-1:LINE_W]),
        .rd_sel   (req_vaddr[LINE_W-1:BYTE_W]),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_word  (line_word),
        .wr_en    (cfill_valid),
        .wr_idx   (cfill_index),
        .wr_tag   (cfill_ptag),
        .wr_line  (cfill_line)
    );

    vipt_hit_logic #(
        .PFN_W (PFN_W)
    ) u_hit (
        .way_hit    (tlb_way_hit),
        .xlat_pfn   (xlat_pfn),
        .line_valid (line_valid),
        .line_tag   (line_tag),
        .tlb_hit    (tlb_hit),
        .cache_hit  (cache_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_tlb_hit   <= 1'b0;
            rsp_cache_hit <= 1'b0;
            rsp_paddr     <= '0;
            rsp_rdata     <= '0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_tlb_hit   <= req_valid && tlb_hit;
            rsp_cache_hit <= req_valid && cache_hit;
            rsp_paddr     <= (req_valid && tlb_hit)
                             ? {xlat_pfn, req_vaddr[PAGE_W-1:0]} : '0;
            rsp_rdata     <= (req_valid && cache_hit) ? line_word : '0;
        end
    end

endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
    parameter int PAGE_W = 14,
    parameter int PA_W   = 40,
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [PAGE_W-1:0] req_off,
    input logic [1:0]        tlb_way_hit,
    input logic              rsp_valid,
    input logic              rsp_tlb_hit,
    input logic              rsp_cache_hit,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [WORD_W-1:0] rsp_rdata
);
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_flags_need_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_tlb_hit && !rsp_cache_hit));

    p_offset_passthru_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid ##1 rsp_tlb_hit) |-> rsp_paddr[PAGE_W-1:0] == $past(req_off));

    p_miss_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_tlb_hit) |-> (!rsp_cache_hit && rsp_paddr == '0 && rsp_rdata == '0));

    p_cache_needs_tlb_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_cache_hit |-> rsp_tlb_hit);

    p_single_way_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $countones(tlb_way_hit) <= 1);

endmodule

bind vipt_lookup vipt_lookup_chk #(
    .PAGE_W (PAGE_W),
    .PA_W   (PA_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_off       (req_vaddr[PAGE_W-1:0]),
    .tlb_way_hit   (tlb_way_hit),
    .rsp_valid     (rsp_valid),
    .rsp_tlb_hit   (rsp_tlb_hit),
    .rsp_cache_hit (rsp_cache_hit),
    .rsp_paddr     (rsp_paddr),
    .rsp_rdata     (rsp_rdata)
);

// File: tb/tb_vipt_lookup.sv
module tb_vipt_lookup;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [63:0]  req_vaddr;
    logic         tfill_valid;
    logic [49:0]  tfill_vpn;
    logic [25:0]  tfill_pfn;
    logic         cfill_valid;
    logic [7:0]   cfill_index;
    logic [25:0]  cfill_ptag;
    logic [511:0] cfill_line;
    logic         rsp_valid;
    logic         rsp_tlb_hit;
    logic         rsp_cache_hit;
    logic [39:0]  rsp_paddr;
    logic [63:0]  rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    vipt_lookup dut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .tfill_valid   (tfill_valid),
        .tfill_vpn     (tfill_vpn),
        .tfill_pfn     (tfill_pfn),
        .cfill_valid   (cfill_valid),
        .cfill_index   (cfill_index),
        .cfill_ptag    (cfill_ptag),
        .cfill_line    (cfill_line),
        .rsp_valid     (rsp_valid),
        .rsp_tlb_hit   (rsp_tlb_hit),
        .rsp_cache_hit (rsp_cache_hit),
        .rsp_paddr     (rsp_paddr),
        .rsp_rdata     (rsp_rdata)
    );

    localparam logic [1:0] OP_LOOK  = 2'd0;
    localparam logic [1:0] OP_TFILL = 2'd1;
    localparam logic [1:0] OP_CFILL = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  rq;     // requirement number printed on failure
        logic [63:0] va;
        logic [25:0] pfn;    // fill frame/tag, or expected frame
        logic [31:0] seed;   // line seed, or expected line seed
        logic        et;     // expected translation hit
        logic        ec;     // expected data hit
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{OP_LOOK,  4'd1,  {43'h1, 7'd5, 14'h0040}, 26'h0,   32'h0,        1'b0, 1'b0}, // R1 empty
        '{OP_TFILL, 4'd7,  {43'h1, 7'd5, 14'h0000}, 26'h100, 32'h0,        1'b0, 1'b0}, // A -> way0
        '{OP_LOOK,  4'd3,  {43'h1, 7'd5, 14'h0048}, 26'h100, 32'h0,        1'b1, 1'b0}, // R3 translate
        '{OP_CFILL, 4'd10, {43'h0, 7'd0, 14'h0040}, 26'h100, 32'h0A0A0001, 1'b0, 1'b0}, // line 1
        '{OP_LOOK,  4'd5,  {43'h1, 7'd5, 14'h0058}, 26'h100, 32'h0A0A0001, 1'b1, 1'b1}, // R5 word 3
        '{OP_TFILL, 4'd7,  {43'h2, 7'd5, 14'h0000}, 26'h100, 32'h0,        1'b0, 1'b0}, // B -> way1
        '{OP_LOOK,  4'd6,  {43'h2, 7'd5, 14'h0040}, 26'h100, 32'h0A0A0001, 1'b1, 1'b1}, // R6 synonym
        '{OP_CFILL, 4'd10, {43'h0, 7'd0, 14'h0040}, 26'h200, 32'h0B0B0002, 1'b0, 1'b0}, // R10 overwrite
        '{OP_LOOK,  4'd6,  {43'h1, 7'd5, 14'h0040}, 26'h100, 32'h0,        1'b1, 1'b0}, // R6 tag mismatch
        '{OP_TFILL, 4'd7,  {43'h3, 7'd5, 14'h0000}, 26'h200, 32'h0,        1'b0, 1'b0}, // C evicts B
        '{OP_LOOK,  4'd7,  {43'h2, 7'd5, 14'h0040}, 26'h0,   32'h0,        1'b0, 1'b0}, // R7 B gone, R4
        '{OP_LOOK,  4'd10, {43'h3, 7'd5, 14'h0040}, 26'h200, 32'h0B0B0002, 1'b1, 1'b1}, // R10 new line
        '{OP_LOOK,  4'd8,  {43'h1, 7'd5, 14'h0040}, 26'h100, 32'h0,        1'b1, 1'b0}, // R8 A still there
        '{OP_TFILL, 4'd7,  {43'h1, 7'd5, 14'h0000}, 26'h300, 32'h0,        1'b0, 1'b0}, // A re-map in place
        '{OP_LOOK,  4'd7,  {43'h1, 7'd5, 14'h0040}, 26'h300, 32'h0,        1'b1, 1'b0}, // R7 new frame
        '{OP_LOOK,  4'd7,  {43'h3, 7'd5, 14'h0078}, 26'h200, 32'h0B0B0002, 1'b1, 1'b1}, // R7 C kept, word 7
        '{OP_LOOK,  4'd3,  {43'h1, 7'd6, 14'h0040}, 26'h0,   32'h0,        1'b0, 1'b0}  // R3 other set
    };

    function automatic logic [511:0] mkline(input logic [31:0] seed);
        logic [511:0] l;
        for (int k = 0; k < 8; k++) begin
            l[k*64 +: 64] = {seed, 24'h0, 8'(k)};
        end
        return l;
    endfunction

    task automatic chk(input int rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        req_valid   = 1'b0;
        req_vaddr   = '0;
        tfill_valid = 1'b0;
        tfill_vpn   = '0;
        tfill_pfn   = '0;
        cfill_valid = 1'b0;
        cfill_index = '0;
        cfill_ptag  = '0;
        cfill_line  = '0;
    endtask

    task automatic set_look(input logic [63:0] va);
        req_valid = 1'b1;
        req_vaddr = va;
    endtask

    task automatic set_tfill(input logic [63:0] va, input logic [25:0] pfn);
        tfill_valid = 1'b1;
        tfill_vpn   = va[63:14];
        tfill_pfn   = pfn;
    endtask

    task automatic set_cfill(input logic [7:0] idx, input logic [25:0] tag,
                             input logic [31:0] seed);
        cfill_valid = 1'b1;
        cfill_index = idx;
        cfill_ptag  = tag;
        cfill_line  = mkline(seed);
    endtask

    // one rising edge, then inputs released; outputs sampled at this negedge
    task automatic tick();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic check_rsp(input int rq, input logic et, input logic ec,
                             input logic [25:0] pfn, input logic [31:0] seed,
                             input logic [63:0] va);
        logic [39:0] ep;
        logic [63:0] ed;
        ep = et ? {pfn, va[13:0]} : 40'h0;
        ed = (et && ec) ? {seed, 24'h0, 5'h0, va[5:3]} : 64'h0;
        chk(rq, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rq, "tlb_hit",   64'(rsp_tlb_hit), 64'(et));
        chk(rq, "cache_hit", 64'(rsp_cache_hit), 64'(et && ec));
        chk(rq, "paddr",     64'(rsp_paddr), 64'(ep));
        chk(rq, "rdata",     rsp_rdata, ed);
    endtask

    task automatic check_idle(input int rq);
        chk(rq, "idle valid", 64'(rsp_valid), 64'd0);
        chk(rq, "idle tlb",   64'(rsp_tlb_hit), 64'd0);
        chk(rq, "idle cache", 64'(rsp_cache_hit), 64'd0);
        chk(rq, "idle paddr", 64'(rsp_paddr), 64'd0);
        chk(rq, "idle rdata", rsp_rdata, 64'd0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        clear_inputs();
        repeat (3) @(negedge clk);
        check_idle(1);                       // R1 outputs zero in reset
        rst = 1'b0;
        @(negedge clk);
        check_idle(1);                       // R1 first cycle after reset

        // Vector table
        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].op)
                OP_LOOK:  set_look(VECS[i].va);
                OP_TFILL: set_tfill(VECS[i].va, VECS[i].pfn);
                default:  set_cfill(VECS[i].va[13:6], VECS[i].pfn, VECS[i].seed);
            endcase
            tick();
            if (VECS[i].op == OP_LOOK) begin
                check_rsp(int'(VECS[i].rq), VECS[i].et, VECS[i].ec,
                          VECS[i].pfn, VECS[i].seed, VECS[i].va);
            end
        end

        // R2: no request, no response
        tick();
        check_idle(2);

        // R9: lookup and line fill to the same line in one cycle
        set_look({43'h3, 7'd5, 14'h0040});
        set_cfill(8'd1, 26'h200, 32'h0C0C0003);
        tick();
        check_rsp(9, 1'b1, 1'b1, 26'h200, 32'h0B0B0002, {43'h3, 7'd5, 14'h0040});
        set_look({43'h3, 7'd5, 14'h0048});
        tick();
        check_rsp(9, 1'b1, 1'b1, 26'h200, 32'h0C0C0003, {43'h3, 7'd5, 14'h0048});

        // R9: lookup and translator fill of the same page in one cycle
        set_look({43'h4, 7'd5, 14'h0100});
        set_tfill({43'h4, 7'd5, 14'h0000}, 26'h001);
        tick();
        check_rsp(9, 1'b0, 1'b0, 26'h0, 32'h0, {43'h4, 7'd5, 14'h0100});
        set_look({43'h4, 7'd5, 14'h0100});
        tick();
        check_rsp(9, 1'b1, 1'b0, 26'h001, 32'h0, {43'h4, 7'd5, 14'h0100});

        // R8: hit and fill on the same set in one cycle, fill mark wins
        set_tfill({43'h1, 7'd9, 14'h0}, 26'h011);
        tick();
        set_tfill({43'h2, 7'd9, 14'h0}, 26'h012);
        tick();
        set_look({43'h2, 7'd9, 14'h0010});
        set_tfill({43'h3, 7'd9, 14'h0}, 26'h013);
        tick();
        check_rsp(8, 1'b1, 1'b0, 26'h012, 32'h0, {43'h2, 7'd9, 14'h0010});
        set_tfill({43'h4, 7'd9, 14'h0}, 26'h014);
        tick();
        set_look({43'h3, 7'd9, 14'h0020});
        tick();
        check_rsp(8, 1'b1, 1'b0, 26'h013, 32'h0, {43'h3, 7'd9, 14'h0020});
        set_look({43'h2, 7'd9, 14'h0020});
        tick();
        check_rsp(8, 1'b0, 1'b0, 26'h0, 32'h0, {43'h2, 7'd9, 14'h0020});
        set_look({43'h1, 7'd9, 14'h0020});
        tick();
        check_rsp(7, 1'b0, 1'b0, 26'h0, 32'h0, {43'h1, 7'd9, 14'h0020});
        set_look({43'h4, 7'd9, 14'h0020});
        tick();
        check_rsp(8, 1'b1, 1'b0, 26'h014, 32'h0, {43'h4, 7'd9, 14'h0020});

        // R1: reset pulse clears both arrays
        rst = 1'b1;
        set_look({43'h3, 7'd5, 14'h0040});
        tick();
        check_idle(1);
        rst = 1'b0;
        @(negedge clk);
        check_idle(1);
        set_look({43'h3, 7'd5, 14'h0040});
        tick();
        check_rsp(1, 1'b0, 1'b0, 26'h0, 32'h0, {43'h3, 7'd5, 14'h0040});
        set_tfill({43'h3, 7'd5, 14'h0}, 26'h200);
        tick();
        set_look({43'h3, 7'd5, 14'h0040});
        tick();
        check_rsp(1, 1'b1, 1'b0, 26'h200, 32'h0, {43'h3, 7'd5, 14'h0040});

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule